// File: doc/BRIEF.md
# Signed-Count Logical Shifter for a 40-bit Accumulator

The block performs a logical shift on the 16-bit upper word of a 40-bit accumulator value. The 40-bit format has an 8-bit guard part (bits 39:32), an upper word (bits 31:16) and a lower word (bits 15:0). Only the upper word of the first operand is shifted. The guard and lower parts of the operand are ignored, and the same parts of the result are written as zero.

The shift count is a 6-bit two's-complement value. It comes either from bits 21:16 of a second operand register or from an immediate port, chosen by a select input. A positive count shifts left and a negative count shifts right. Vacated positions fill with zeros. Defined counts run from -16 to +16.

Each operation registers its result, and may also update five status flags. The carry-like flag DC takes one of several meanings, picked by a 3-bit mode field. Conditional operations still write the result but leave every flag untouched.

Top module: `dsp_lshift_unit`

## Requirements
- R1: When `op_valid` is 1, `dst[31:16]` becomes `src1[31:16]` shifted by the selected count. `src1[39:32]` and `src1[15:0]` have no effect on any output.
- R2: `dst[39:32]` and `dst[15:0]` are always 0.
- R3: With `use_imm`=1 the count is `imm_amt`; with `use_imm`=0 it is `src2[21:16]`. Both are 6-bit two's complement. A count k>0 shifts left by k, a count k<0 shifts right by -k, and vacated bits are 0.
- R4: A count of 0 passes the upper word through unchanged. A count of +16 or -16 gives an all-zero upper word.
- R5: With `dc_mode`=3'b000 (carry mode), DC is the last bit shifted out of the 16-bit field. For a left shift by k this is source bit 32-k. For a right shift by k it is source bit 15+k. For a count of 0 it is 0.
- R6: With `dc_mode`=3'b001, DC equals `dst[31]`. With `dc_mode`=3'b010, DC is 1 exactly when `dst[31:16]` is zero. With any other `dc_mode`, DC is 0.
- R7: N equals `dst[31]`. Z is 1 when all 40 result bits are zero. V is always 0. GT is 1 when the result is neither zero nor negative.
- R8: When `cond_op` is 1 on a valid operation, `dst` is updated but all five flags keep their previous values.
- R9: Outputs change only on the rising clock edge at which `op_valid` is 1, and appear one cycle after the inputs. A synchronous `rst` clears `dst` and all flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe; registers load on this edge |
| cond_op | input | 1 | 1 = conditional operation, so flags are not written |
| use_imm | input | 1 | 1 = count from `imm_amt`, 0 = count from `src2[21:16]` |
| src1 | input | 40 | Operand whose upper word is shifted |
| src2 | input | 40 | Register operand carrying the count in bits 21:16 |
| imm_amt | input | 6 | Immediate signed count |
| dc_mode | input | 3 | Selects the meaning of DC |
| dst | output | 40 | Registered result |
| flag_dc | output | 1 | Mode-dependent flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag (always 0) |
| flag_gt | output | 1 | Greater-than-zero flag |

## Verification
The result and every flag are due exactly one rising edge after a valid operation is presented, and nothing changes on edges where the strobe is low. The bench drives each operation on a falling edge, waits for the next rising edge, and samples a nanosecond later. It then holds the strobe low for a cycle, so each sample reflects only the operation that was just presented. The tests for conditional operations and idle cycles sample over several edges, to show that flags or results stay put while new operand values sit on the inputs.

// File: rtl/lsh_pkg.sv
package lsh_pkg;

  typedef enum logic [2:0] {
    DCM_CARRY = 3'b000,
    DCM_NEG   = 3'b001,
    DCM_ZERO  = 3'b010
  } dc_mode_e;

  typedef struct packed {
    logic gt;
    logic z;
    logic n;
    logic v;
    logic dc;
  } flags_t;

  localparam flags_t FLAGS_RESET = '{gt: 1'b0, z: 1'b0, n: 1'b0, v: 1'b0, dc: 1'b0};

endpackage

// File: rtl/lsh_amt_sel.sv
module lsh_amt_sel #(
  parameter int ACC_W   = 40,
  parameter int AMT_W   = 6,
  parameter int AMT_LSB = 16
) (
  input  logic [ACC_W-1:0] src2,
  input  logic [AMT_W-1:0] imm_amt,
  input  logic             use_imm,
  output logic [AMT_W-1:0] amt_eff,
  output logic             go_left,
  output logic [AMT_W-1:0] amt_mag
);

  logic [AMT_W-1:0] reg_amt;

  assign reg_amt = src2[AMT_LSB +: AMT_W];

  always_comb begin
    amt_eff = use_imm ? imm_amt : reg_amt;
    go_left = ~amt_eff[AMT_W-1];
    if (amt_eff[AMT_W-1]) begin
      amt_mag = (~amt_eff) + {{(AMT_W-1){1'b0}}, 1'b1};
    end else begin
      amt_mag = amt_eff;
    end
  end

endmodule

// File: rtl/lsh_core.sv
module lsh_core #(
  parameter int FIELD_W = 16,
  parameter int AMT_W   = 6
) (
  input  logic [FIELD_W-1:0] field_in,
  input  logic               go_left,
  input  logic [AMT_W-1:0]   amt_mag,
  output logic [FIELD_W-1:0] field_out,
  output logic               shifted_out
);

  localparam int WIDE_W = 3 * FIELD_W;

  logic [WIDE_W-1:0] left_ext;
  logic [WIDE_W-1:0] right_ext;
  logic [WIDE_W-1:0] left_sh;
  logic [WIDE_W-1:0] right_sh;

  // Left: field sits at the bottom; the bit just above it is the last one out.
  // Right: field sits one field-width up; the bit just below it is the last one out.
  assign left_ext  = {{(2*FIELD_W){1'b0}}, field_in};
  assign right_ext = {{FIELD_W{1'b0}}, field_in, {FIELD_W{1'b0}}};
  assign left_sh   = left_ext << amt_mag;
  assign right_sh  = right_ext >> amt_mag;

  always_comb begin
    if (go_left) begin
      field_out   = left_sh[FIELD_W-1:0];
      shifted_out = left_sh[FIELD_W];
    end else begin
      field_out   = right_sh[2*FIELD_W-1:FIELD_W];
      shifted_out = right_sh[FIELD_W-1];
    end
  end

endmodule

// File: rtl/lsh_flags.sv
module lsh_flags
  import lsh_pkg::*;
#(
  parameter int ACC_W   = 40,
  parameter int FIELD_W = 16
) (
  input  logic [ACC_W-1:0]   result,
  input  logic [FIELD_W-1:0] field,
  input  logic               shifted_out,
  input  logic [2:0]         dc_mode,
  output flags_t             flags
);

  logic res_zero;
  logic res_neg;
  logic field_zero;

  assign res_zero   = (result == '0);
  assign res_neg    = field[FIELD_W-1];
  assign field_zero = (field == '0);

  always_comb begin
    flags.n  = res_neg;
    flags.z  = res_zero;
    flags.v  = 1'b0;
    flags.gt = ~res_zero & ~res_neg;
    case (dc_mode)
      DCM_CARRY: flags.dc = shifted_out;
      DCM_NEG:   flags.dc = res_neg;
      DCM_ZERO:  flags.dc = field_zero;
      default:   flags.dc = 1'b0;
    endcase
  end

endmodule

// File: rtl/dsp_lshift_unit.sv
module dsp_lshift_unit
  import lsh_pkg::*;
#(
  parameter int GUARD_W = 8,
  parameter int HI_W    = 16,
  parameter int LO_W    = 16,
  parameter int AMT_W   = 6,
  parameter int AMT_LSB = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          op_valid,
  input  logic                          cond_op,
  input  logic                          use_imm,
  input  logic [GUARD_W+HI_W+LO_W-1:0]  src1,
  input  logic [GUARD_W+HI_W+LO_W-1:0]  src2,
  input  logic [AMT_W-1:0]              imm_amt,
  input  logic [2:0]                    dc_mode,
  output logic [GUARD_W+HI_W+LO_W-1:0]  dst,
  output logic                          flag_dc,
  output logic                          flag_n,
  output logic                          flag_z,
  output logic                          flag_v,
  output logic                          flag_gt
);

  localparam int ACC_W  = GUARD_W + HI_W + LO_W;
  localparam int HI_LSB = LO_W;

  logic [AMT_W-1:0] amt_eff;
  logic [AMT_W-1:0] amt_mag;
  logic             go_left;
  logic [HI_W-1:0]  field_in;
  logic [HI_W-1:0]  field_out;
  logic             shifted_out;
  logic [ACC_W-1:0] result;
  flags_t           flags_next;
  flags_t           flags_q;
  logic [ACC_W-1:0] dst_q;

  assign field_in = src1[HI_LSB +: HI_W];

  lsh_amt_sel #(
    .ACC_W   (ACC_W),
    .AMT_W   (AMT_W),
    .AMT_LSB (AMT_LSB)
  ) u_amt (
    .src2    (src2),
    .imm_amt (imm_amt),
    .use_imm (use_imm),
    .amt_eff (amt_eff),
    .go_left (go_left),
    .amt_mag (amt_mag)
  );

  lsh_core #(
    .FIELD_W (HI_W),
    .AMT_W   (AMT_W)
  ) u_core (
    .field_in    (field_in),
    .go_left     (go_left),
    .amt_mag     (amt_mag),
    .field_out   (field_out),
    .shifted_out (shifted_out)
  );

  assign result = {{GUARD_W{1'b0}}, field_out, {LO_W{1'b0}}};

  lsh_flags #(
    .ACC_W   (ACC_W),
    .FIELD_W (HI_W)
  ) u_flags (
    .result      (result),
    .field       (field_out),
    .shifted_out (shifted_out),
    .dc_mode     (dc_mode),
    .flags       (flags_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_q   <= '0;
      flags_q <= FLAGS_RESET;
    end else if (op_valid) begin
      dst_q <= result;
      if (!cond_op) begin
        flags_q <= flags_next;
      end
    end
  end

  assign dst     = dst_q;
  assign flag_dc = flags_q.dc;
  assign flag_n  = flags_q.n;
  assign flag_z  = flags_q.z;
  assign flag_v  = flags_q.v;
  assign flag_gt = flags_q.gt;

endmodule

// File: rtl/lsh_chk.sv
module lsh_chk #(
  parameter int ACC_W  = 40,
  parameter int HI_W   = 16,
  parameter int LO_W   = 16,
  parameter int AMT_W  = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic             cond_op,
  input logic [ACC_W-1:0] src1,
  input logic [AMT_W-1:0] amt_eff,
  input logic [ACC_W-1:0] dst,
  input logic             flag_dc,
  input logic             flag_n,
  input logic             flag_z,
  input logic             flag_v,
  input logic             flag_gt
);

  logic [4:0] flag_vec;
  assign flag_vec = {flag_gt, flag_z, flag_n, flag_v, flag_dc};

  a_r2_parts_zero: assert property (@(posedge clk) disable iff (rst)
    (dst[ACC_W-1:LO_W+HI_W] == '0) && (dst[LO_W-1:0] == '0));

  a_r4_zero_count_pass: assert property (@(posedge clk) disable iff (rst)
    (op_valid && amt_eff == '0) |=> dst[LO_W +: HI_W] == $past(src1[LO_W +: HI_W]));

  a_r7_v_clear: assert property (@(posedge clk) disable iff (rst) !flag_v);

  a_r7_gt_excl: assert property (@(posedge clk) disable iff (rst)
    flag_gt |-> (!flag_z && !flag_n));

  a_r8_cond_keeps_flags: assert property (@(posedge clk) disable iff (rst)
    (op_valid && cond_op) |=> $stable(flag_vec));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(dst) && $stable(flag_vec)));

endmodule

bind dsp_lshift_unit lsh_chk #(
  .ACC_W (GUARD_W + HI_W + LO_W),
  .HI_W  (HI_W),
  .LO_W  (LO_W),
  .AMT_W (AMT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_valid (op_valid),
  .cond_op  (cond_op),
  .src1     (src1),
  .amt_eff  (amt_eff),
  .dst      (dst),
  .flag_dc  (flag_dc),
  .flag_n   (flag_n),
  .flag_z   (flag_z),
  .flag_v   (flag_v),
  .flag_gt  (flag_gt)
);

// File: tb/dsp_lshift_unit_tb.sv
`timescale 1ns/1ps
module dsp_lshift_unit_tb;

  typedef struct packed {
    logic [39:0] s1;
    logic [5:0]  amt;
    logic        imm;
    logic [2:0]  mode;
    logic [15:0] hi;
    logic        dc;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{40'hFF_8001_ABCD, 6'h01, 1'b0, 3'b000, 16'h0002, 1'b1},
    '{40'h12_8001_0000, 6'h3F, 1'b1, 3'b000, 16'h4000, 1'b1},
    '{40'hAA_1234_FFFF, 6'h00, 1'b0, 3'b000, 16'h1234, 1'b0},
    '{40'h55_0001_1111, 6'h10, 1'b1, 3'b000, 16'h0000, 1'b1},
    '{40'h01_8000_8000, 6'h30, 1'b0, 3'b000, 16'h0000, 1'b1},
    '{40'hC3_00FF_0F0F, 6'h08, 1'b1, 3'b001, 16'hFF00, 1'b1},
    '{40'h3C_00FF_F0F0, 6'h04, 1'b0, 3'b001, 16'h0FF0, 1'b0},
    '{40'h00_000F_FFFF, 6'h3C, 1'b1, 3'b010, 16'h0000, 1'b1},
    '{40'hFF_0F0F_0000, 6'h3C, 1'b0, 3'b010, 16'h00F0, 1'b0},
    '{40'h77_A5A5_5A5A, 6'h03, 1'b1, 3'b101, 16'h2D28, 1'b0},
    '{40'h80_7FFF_0001, 6'h31, 1'b0, 3'b000, 16'h0000, 1'b1},
    '{40'h0F_C000_8000, 6'h01, 1'b1, 3'b000, 16'h8000, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic        cond_op;
  logic        use_imm;
  logic [39:0] src1;
  logic [39:0] src2;
  logic [5:0]  imm_amt;
  logic [2:0]  dc_mode;
  logic [39:0] dst;
  logic        flag_dc, flag_n, flag_z, flag_v, flag_gt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dsp_lshift_unit u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .cond_op(cond_op),
    .use_imm(use_imm), .src1(src1), .src2(src2), .imm_amt(imm_amt),
    .dc_mode(dc_mode), .dst(dst), .flag_dc(flag_dc), .flag_n(flag_n),
    .flag_z(flag_z), .flag_v(flag_v), .flag_gt(flag_gt)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Flags as {gt,z,n,v,dc}
  function automatic logic [4:0] flags_from(input logic [15:0] hi, input logic dc);
    logic z;
    z = (hi == 16'h0);
    return {~z & ~hi[15], z, hi[15], 1'b0, dc};
  endfunction

  task automatic drive_op(input logic [39:0] s1, input logic [5:0] amt, input logic imm,
                          input logic [2:0] mode, input logic cnd);
    @(negedge clk);
    op_valid = 1'b1;
    cond_op  = cnd;
    use_imm  = imm;
    src1     = s1;
    src2     = {8'hA5, 10'h3FF, (imm ? ~amt : amt), 16'h5A5A};
    imm_amt  = imm ? amt : ~amt;
    dc_mode  = mode;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    rst = 1'b1; op_valid = 1'b0; cond_op = 1'b0; use_imm = 1'b0;
    src1 = '0; src2 = '0; imm_amt = '0; dc_mode = '0;
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    check(dst == 40'h0, "R9 reset dst", 64'(dst), 64'h0);
    check({flag_gt, flag_z, flag_n, flag_v, flag_dc} == 5'h0, "R9 reset flags",
          64'({flag_gt, flag_z, flag_n, flag_v, flag_dc}), 64'h0);
    @(negedge clk);
    rst = 1'b0;

    // R1 R2 R3 R4 R5 R6 R7: vector walk
    for (int i = 0; i < NV; i++) begin
      drive_op(VECS[i].s1, VECS[i].amt, VECS[i].imm, VECS[i].mode, 1'b0);
      check(dst == {8'h00, VECS[i].hi, 16'h0000}, $sformatf("R1/R2/R3/R4 vector %0d dst", i),
            64'(dst), 64'({8'h00, VECS[i].hi, 16'h0000}));
      check({flag_gt, flag_z, flag_n, flag_v, flag_dc} == flags_from(VECS[i].hi, VECS[i].dc),
            $sformatf("R5/R6/R7 vector %0d flags", i),
            64'({flag_gt, flag_z, flag_n, flag_v, flag_dc}), 64'(flags_from(VECS[i].hi, VECS[i].dc)));
      idle();
    end

    // R8: conditional op writes dst but keeps flags (last vector left gt=0,z=0,n=1,v=0,dc=1)
    drive_op(40'hFF_0001_FFFF, 6'h00, 1'b0, 3'b010, 1'b1);
    check(dst == 40'h00_0001_0000, "R8 cond dst written", 64'(dst), 64'h0000_0001_0000);
    check({flag_gt, flag_z, flag_n, flag_v, flag_dc} == 5'b00101, "R8 cond flags kept",
          64'({flag_gt, flag_z, flag_n, flag_v, flag_dc}), 64'h05);
    idle();

    // R9: strobe low, new operands present, nothing changes over several edges
    @(negedge clk);
    op_valid = 1'b0; cond_op = 1'b0; src1 = 40'hFF_FFFF_FFFF; dc_mode = 3'b000;
    src2 = '0; imm_amt = 6'h02; use_imm = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(dst == 40'h00_0001_0000, "R9 idle dst hold", 64'(dst), 64'h0000_0001_0000);
    check({flag_gt, flag_z, flag_n, flag_v, flag_dc} == 5'b00101, "R9 idle flags hold",
          64'({flag_gt, flag_z, flag_n, flag_v, flag_dc}), 64'h05);

    // R1: guard/lower of src1 ignored - two operands differing only there give same output
    drive_op(40'h00_0F00_0000, 6'h3E, 1'b0, 3'b000, 1'b0);
    check(dst == 40'h00_03C0_0000, "R1 src1 low parts ignored (a)", 64'(dst), 64'h0000_03C0_0000);
    idle();
    drive_op(40'hFF_0F00_FFFF, 6'h3E, 1'b0, 3'b000, 1'b0);
    check(dst == 40'h00_03C0_0000, "R1 src1 low parts ignored (b)", 64'(dst), 64'h0000_03C0_0000);
    check({flag_gt, flag_z, flag_n, flag_v, flag_dc} == 5'b10000, "R5 R7 right by 2 carry 0",
          64'({flag_gt, flag_z, flag_n, flag_v, flag_dc}), 64'h10);
    idle();

    // R7: zero result sets Z after an unconditional op
    drive_op(40'h00_0000_1234, 6'h05, 1'b1, 3'b011, 1'b0);
    check({flag_gt, flag_z, flag_n, flag_v, flag_dc} == 5'b01000, "R7 zero result flags, R6 mode 3 dc 0",
          64'({flag_gt, flag_z, flag_n, flag_v, flag_dc}), 64'h08);
    idle();

    // R9: reset mid-run clears state
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check(dst == 40'h0 && {flag_gt, flag_z, flag_n, flag_v, flag_dc} == 5'h0, "R9 reset clears",
          64'({dst, flag_gt, flag_z, flag_n, flag_v, flag_dc}), 64'h0);
    @(negedge clk);
    rst = 1'b0;

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule